// File: doc/BRIEF.md
# ADC-to-DDC Input Crossbar

This block sits between two ADC sample buses and a bank of digital down-converter channels. For every channel it picks, on its own and for each of the in-phase (I) and quadrature (Q) inputs, one of three sources: converter A, converter B, or a constant zero. The routed samples are registered on the sample clock, so each channel input lags the converters by exactly one cycle.

The routing is set by one 32-bit control word, loaded through a single-cycle write strobe and always readable on a read-back port. The word holds one 4-bit slot per channel. The low two bits of a slot choose the I source and the high two bits choose the Q source. The number of channels is a parameter, from one to eight. The slots of channels that are not built are stored but have no effect. The word is loaded whole, so every channel switches to its new routing on the same sample.

Top module: `ddc_input_xbar`

## Requirements
- R1: While `rst_n` is low and after its release, the control word reads back as 0x00000004 and every channel output is zero until the first routed sample lands.
- R2: Channel c takes its I selector from word bits [4c+1:4c] and its Q selector from bits [4c+3:4c+2].
- R3: Selector code 00 routes converter A (`adc_a`) onto the selected input, with its signed value unchanged.
- R4: Selector code 01 routes converter B (`adc_b`) onto the selected input, with its signed value unchanged.
- R5: Selector codes 10 and 11 both drive the selected input to zero, whatever the converter values are.
- R6: Each channel output equals the chosen source as sampled at the previous rising clock edge, a latency of one cycle.
- R7: A word written with `cfg_wr_en` high at one edge governs the samples registered from the following edge onward. The sample registered at the write edge still uses the old word, and all channels switch on the same edge.
- R8: `cfg_rd_data` returns all 32 stored bits, including slots of channels that are not built, and holds its value while no write occurs.
- R9: Slots above channel NUM_CH-1 have no effect on any channel output.
- R10: The I and Q selectors of each channel act independently of each other and of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word to store |
| cfg_rd_data | output | 32 | Stored control word |
| adc_a | input | SAMPLE_W | Signed sample from converter A |
| adc_b | input | SAMPLE_W | Signed sample from converter B |
| ddc_i | output | NUM_CH*SAMPLE_W | Packed I inputs of the channels, channel 0 in the low bits |
| ddc_q | output | NUM_CH*SAMPLE_W | Packed Q inputs of the channels, channel 0 in the low bits |

## Verification
The properties assume that converter samples and the write strobe are stable around the rising edge, and that reset is released away from that edge, so that the word seen at one edge governs the routed sample seen at the next. The bench changes every input on the falling edge and drives reset the same way, so each property compares two clean, consecutive edge samples. Routing is checked against a behavioural model for every code in both the I and Q fields of both channels. The stimulus also includes a write whose unused upper slots are all ones, and a write that lands exactly on a sample boundary.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int CFG_W  = 32;
  localparam int SLOT_W = 4;
  localparam int SEL_W  = 2;
  localparam int MAX_CH = CFG_W / SLOT_W;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0004;

  typedef enum logic [1:0] {
    SRC_CONV_A = 2'd0,
    SRC_CONV_B = 2'd1,
    SRC_ZERO   = 2'd2
  } src_e;

  // The upper bit of a selector forces zero, whatever the lower bit is.
  function automatic src_e decode_sel(input logic [SEL_W-1:0] code);
    if (code[1])      return SRC_ZERO;
    else if (code[0]) return SRC_CONV_B;
    else              return SRC_CONV_A;
  endfunction

endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg
  import xbar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);

  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/xbar_lane.sv
module xbar_lane
  import xbar_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [SEL_W-1:0]    sel_q,
  input  logic [SAMPLE_W-1:0] adc_a,
  input  logic [SAMPLE_W-1:0] adc_b,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q
);

  logic [SAMPLE_W-1:0] nxt_i;
  logic [SAMPLE_W-1:0] nxt_q;
  src_e                src_i;
  src_e                src_q;

  function automatic logic [SAMPLE_W-1:0] route(
    input src_e                s,
    input logic [SAMPLE_W-1:0] a,
    input logic [SAMPLE_W-1:0] b
  );
    case (s)
      SRC_CONV_A: return a;
      SRC_CONV_B: return b;
      default:    return '0;
    endcase
  endfunction

  always_comb begin
    src_i = decode_sel(sel_i);
    src_q = decode_sel(sel_q);
    nxt_i = route(src_i, adc_a, adc_b);
    nxt_q = route(src_q, adc_a, adc_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i <= '0;
      out_q <= '0;
    end else begin
      out_i <= nxt_i;
      out_q <= nxt_q;
    end
  end

endmodule

// File: rtl/ddc_input_xbar.sv
module ddc_input_xbar
  import xbar_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int NUM_CH   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr_en,
  input  logic [31:0]                cfg_wr_data,
  output logic [31:0]                cfg_rd_data,
  input  logic [SAMPLE_W-1:0]        adc_a,
  input  logic [SAMPLE_W-1:0]        adc_b,
  output logic [NUM_CH*SAMPLE_W-1:0] ddc_i,
  output logic [NUM_CH*SAMPLE_W-1:0] ddc_q
);

  localparam int USED_W = NUM_CH * SLOT_W;

  logic [CFG_W-1:0] cfg_word;

  xbar_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg_word)
  );

  assign cfg_rd_data = cfg_word;

  // Only the low USED_W bits reach a lane; higher slots are held for read-back.
  logic [USED_W-1:0] slot_bits;
  assign slot_bits = cfg_word[USED_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    localparam int LSB = ch * SLOT_W;
    xbar_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (slot_bits[LSB +: SEL_W]),
      .sel_q (slot_bits[LSB + SEL_W +: SEL_W]),
      .adc_a (adc_a),
      .adc_b (adc_b),
      .out_i (ddc_i[ch*SAMPLE_W +: SAMPLE_W]),
      .out_q (ddc_q[ch*SAMPLE_W +: SAMPLE_W])
    );
  end

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int SAMPLE_W = 14,
  parameter int NUM_CH   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_wr_en,
  input logic [31:0]                cfg_wr_data,
  input logic [31:0]                cfg_rd_data,
  input logic [SAMPLE_W-1:0]        adc_a,
  input logic [SAMPLE_W-1:0]        adc_b,
  input logic [NUM_CH*SAMPLE_W-1:0] ddc_i,
  input logic [NUM_CH*SAMPLE_W-1:0] ddc_q
);

  // R7: a write lands in the stored word at the strobe edge.
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

  // R8: without a write the stored word holds.
  a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rd_data));

  // R3: code 00 on channel 0 I routes converter A one cycle later.
  a_r3_i0_from_a: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[1:0] == 2'b00 |=> ddc_i[SAMPLE_W-1:0] == $past(adc_a));

  // R4: code 01 on channel 0 Q routes converter B one cycle later.
  a_r4_q0_from_b: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[3:2] == 2'b01 |=> ddc_q[SAMPLE_W-1:0] == $past(adc_b));

  // R5: an MSB of one forces zero on channel 0 I and Q.
  a_r5_i0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[1] |=> ddc_i[SAMPLE_W-1:0] == '0);
  a_r5_q0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[3] |=> ddc_q[SAMPLE_W-1:0] == '0);

  // R1: outputs are zero while reset is held.
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_outputs: assert (ddc_i == '0 && ddc_q == '0 && cfg_rd_data == 32'h4);
    end
  end

endmodule

bind ddc_input_xbar xbar_chk #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .adc_a       (adc_a),
  .adc_b       (adc_b),
  .ddc_i       (ddc_i),
  .ddc_q       (ddc_q)
);

// File: tb/ddc_input_xbar_tb.sv
module ddc_input_xbar_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 14;
  localparam int NCH        = 2;
  localparam int WATCHDOG   = 20000;

  logic              clk;
  logic              rst_n;
  logic              cfg_wr_en;
  logic [31:0]       cfg_wr_data;
  logic [31:0]       cfg_rd_data;
  logic [SW-1:0]     adc_a;
  logic [SW-1:0]     adc_b;
  logic [NCH*SW-1:0] ddc_i;
  logic [NCH*SW-1:0] ddc_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  ddc_input_xbar #(.SAMPLE_W(SW), .NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .adc_a(adc_a), .adc_b(adc_b),
    .ddc_i(ddc_i), .ddc_q(ddc_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: stored word plus one registered sample per input.
  logic [31:0] m_cfg;
  logic [SW-1:0] m_i [NCH];
  logic [SW-1:0] m_q [NCH];

  function automatic logic [SW-1:0] pick(input int code, input logic [SW-1:0] a,
                                         input logic [SW-1:0] b);
    if (code >= 2)      return '0;
    else if (code == 1) return b;
    else                return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= 32'h4;
      for (int c = 0; c < NCH; c++) begin
        m_i[c] <= '0;
        m_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        m_i[c] <= pick(int'((m_cfg >> (4*c)) & 32'h3), adc_a, adc_b);
        m_q[c] <= pick(int'((m_cfg >> (4*c + 2)) & 32'h3), adc_a, adc_b);
      end
      if (cfg_wr_en) m_cfg <= cfg_wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string code_tag(input int code);
    if (code >= 2)      return "R5";
    else if (code == 1) return "R4";
    else                return "R3";
  endfunction

  // Per-clock comparison of every port against the model (R2 R6 R10 and the code tags).
  task automatic compare_all();
    check("R8 readback", cfg_rd_data, m_cfg);
    for (int c = 0; c < NCH; c++) begin
      check({code_tag(int'((m_cfg >> (4*c)) & 32'h3)), " R2 R6 R10 I"},
            32'(ddc_i[c*SW +: SW]), 32'(m_i[c]));
      check({code_tag(int'((m_cfg >> (4*c + 2)) & 32'h3)), " R2 R6 R10 Q"},
            32'(ddc_q[c*SW +: SW]), 32'(m_q[c]));
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    adc_a = SW'($urandom);
    adc_b = SW'($urandom);
  endtask

  task automatic write_cfg(input logic [31:0] w);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = w;
    step();
    cfg_wr_en   = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    adc_a = 14'h123; adc_b = 14'h2AB;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset word", cfg_rd_data, 32'h4);
    check("R1 reset I", 32'(ddc_i), 32'h0);
    check("R1 reset Q", 32'(ddc_q), 32'h0);
    rst_n = 1'b1;
    step();
    check("R1 word after release", cfg_rd_data, 32'h4);

    // R6 R7: write on a known sample boundary
    adc_a = 14'd100; adc_b = 14'h3FFB;      // -5
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h5;  // ch0 I -> B
    @(negedge clk);
    check("R7 old word on write edge", 32'(ddc_i[SW-1:0]), 32'd100);
    check("R7 stored after write", cfg_rd_data, 32'h5);
    cfg_wr_en = 1'b0;
    @(negedge clk);
    check("R7 new word next sample", 32'(ddc_i[SW-1:0]), 32'h3FFB);
    check("R6 Q from B one cycle", 32'(ddc_q[SW-1:0]), 32'h3FFB);

    // R2 R3 R4 R5 R10: code patterns across both channels
    write_cfg(32'h4444_4444);
    repeat (20) step();
    write_cfg(32'h0000_001B);
    repeat (20) step();
    write_cfg(32'h0000_00E4);
    repeat (20) step();
    write_cfg(32'h0000_0050);
    repeat (20) step();
    write_cfg(32'h0000_0A27);
    repeat (20) step();

    // R8 R9: unused slots stored but without effect
    write_cfg(32'hFFFF_FF44);
    adc_a = 14'd77; adc_b = 14'd901;
    @(negedge clk);
    check("R8 full word readback", cfg_rd_data, 32'hFFFF_FF44);
    check("R9 ch1 I ignores upper slots", 32'(ddc_i[SW +: SW]), 32'd77);
    check("R9 ch1 Q ignores upper slots", 32'(ddc_q[SW +: SW]), 32'd901);
    repeat (20) step();

    // Back-to-back writes: each sample follows the word stored before it (R7)
    for (int k = 0; k < 16; k++) write_cfg($urandom);
    repeat (10) step();

    done = 1'b1;
    finish_run();
  end

endmodule